// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Sequencer

This block produces the four gate commands of a full-bridge converter that regulates power by shifting the phase of one bridge leg against the other. Each leg drives two complementary outputs, and each output turns on only after a programmable dead time. The A leg (outputs `a1`, `a2`) flips on every oscillator tick (`osc_tick`). The B leg (outputs `b1`, `b2`) flips when the duty-termination pulse (`term_pulse`) arrives. That pulse comes from the modulator comparator or from the current-limit comparator. The gap between the two flips sets the overlap of the diagonal switch pairs, and so the power delivered. Each leg changes state once per tick, so each output runs at half the tick rate.

A half-period controller holds the phase of each leg. It has two states. In `HP_OPEN` no termination has acted yet in the current half period. In `HP_SHUT` a termination has acted, and further pulses are ignored until the next tick. Its transitions are:
- `T_TERM`: open to shut, on a termination pulse. The B phase flips.
- `T_FORCE`: open to open, on a tick. Both phases flip, because a missing termination is forced at the edge.
- `T_TICK`: shut to open, on a tick. Only the A phase flips.
- `T_INHIBIT`: any state to open, on inhibit. Both phases clear.

Each leg runs its own state machine with four states:
- `LEG_OFF`: both outputs low.
- `LEG_DEAD`: both outputs low while the dead-time counter runs.
- `LEG_ON0`: first output high (`a2` or `b1`).
- `LEG_ON1`: second output high (`a1` or `b2`).

Its transitions are:
- `L_START`: off to dead. The counter loads the leg's setting.
- `L_EXPIRE`: dead to the on-state that matches the current phase, when the counter reaches zero.
- `L_TURN_OFF`: on to dead when the phase changes. The counter loads the setting.
- `L_KILL`: any state to off, on inhibit.

The `inhibit` input collects undervoltage lockout, external shutdown and fault shutdown.

Top module: `psfb_seq`

## Requirements
- R1: While `rst_n` is low or `inhibit` is high, all four outputs are low. An inhibit forces them low in the same clock cycle in which it is high.
- R2: `a1` and `a2` are never high together, and `b1` and `b2` are never high together.
- R3: Leaving reset starts a power interval with `a2` and `b1`. Each of these stays low for exactly setting+1 sampled cycles after the release and then rises. `a1` and `b2` stay low.
- R4: Take a tick sampled at clock edge k. The high A output falls after edge k+1. Both A outputs then stay low for exactly `dead_a`+1 cycles, and then the other A output rises.
- R5: The first termination pulse of a half period acts on the B leg with the same timing as R4, using `dead_b`.
- R6: A termination pulse arriving after one has already acted in the same half period has no effect on the outputs.
- R7: A tick in a half period in which no termination has acted flips the B leg at the same edge as the A leg. If a tick and a termination pulse arrive in the same cycle, the B leg flips exactly once.
- R8: The dead-time setting is captured when a dead interval begins. A change during that interval takes effect only at the next interval.
- R9: Ticks and termination pulses during inhibit are ignored. After inhibit is released, the sequence restarts from `a2`/`b1`, as in R3, whatever phase was active before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One-cycle pulse per oscillator edge |
| term_pulse | input | 1 | One-cycle duty-termination pulse (modulator or current limit) |
| dead_a | input | DEAD_W | A-leg dead time in clock cycles |
| dead_b | input | DEAD_W | B-leg dead time in clock cycles |
| inhibit | input | 1 | Forces all outputs low and resets the sequence |
| a1 | output | 1 | A-leg output, on in odd half periods |
| a2 | output | 1 | A-leg output, on in even half periods |
| b1 | output | 1 | B-leg output paired with `a2` |
| b2 | output | 1 | B-leg output paired with `a1` |

## Verification
The hardest case to reach from the ports is a change of the dead-time setting while a dead interval is already counting. The bench fires a termination pulse and, two cycles into the resulting B-leg gap, writes a new `dead_b`. It measures that this gap keeps the old length and that the following B gap uses the new one. A second hard case is the pair of tick corner cases: a tick with no prior termination, and a tick coinciding with a termination. The bench reaches these by timing its pulses relative to a known half-period state and watching both legs in parallel.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
    localparam int NUM_LEGS = 2;
    localparam int LEG_A    = 0;
    localparam int LEG_B    = 1;

    typedef enum logic [1:0] {
        LEG_OFF,
        LEG_DEAD,
        LEG_ON0,
        LEG_ON1
    } leg_state_t;

    typedef enum logic {
        HP_OPEN,
        HP_SHUT
    } half_state_t;
endpackage

// File: rtl/psfb_phase_ctl.sv
module psfb_phase_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic inhibit,
    input  logic osc_tick,
    input  logic term_pulse,
    output logic phase_a,
    output logic phase_b
);
    import psfb_pkg::*;

    half_state_t hp_q, hp_d;
    logic        pa_q, pa_d;
    logic        pb_q, pb_d;

    // next-state logic of the half-period controller
    always_comb begin
        hp_d = hp_q;
        pa_d = pa_q;
        pb_d = pb_q;
        if (inhibit) begin                       // T_INHIBIT
            hp_d = HP_OPEN;
            pa_d = 1'b0;
            pb_d = 1'b0;
        end else begin
            unique case (hp_q)
                HP_OPEN: begin
                    if (osc_tick) begin          // T_FORCE (also covers coincident termination)
                        pa_d = ~pa_q;
                        pb_d = ~pb_q;
                    end else if (term_pulse) begin // T_TERM
                        pb_d = ~pb_q;
                        hp_d = HP_SHUT;
                    end
                end
                HP_SHUT: begin
                    if (osc_tick) begin          // T_TICK
                        pa_d = ~pa_q;
                        hp_d = HP_OPEN;
                    end
                end
                default: hp_d = HP_OPEN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hp_q <= HP_OPEN;
            pa_q <= 1'b0;
            pb_q <= 1'b0;
        end else begin
            hp_q <= hp_d;
            pa_q <= pa_d;
            pb_q <= pb_d;
        end
    end

    // outputs
    always_comb begin
        phase_a = pa_q;
        phase_b = pb_q;
    end
endmodule

// File: rtl/psfb_leg.sv
module psfb_leg #(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inhibit,
    input  logic              phase,
    input  logic [DEAD_W-1:0] dead,
    output logic              out0,
    output logic              out1
);
    import psfb_pkg::*;

    localparam logic [DEAD_W-1:0] CNT_ZERO = '0;
    localparam logic [DEAD_W-1:0] CNT_ONE  = DEAD_W'(1);

    leg_state_t        st_q, st_d;
    logic [DEAD_W-1:0] cnt_q, cnt_d;

    // next-state logic; the counter loads the setting only on entry to LEG_DEAD
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (inhibit) begin                       // L_KILL
            st_d  = LEG_OFF;
            cnt_d = CNT_ZERO;
        end else begin
            unique case (st_q)
                LEG_OFF: begin                   // L_START
                    st_d  = LEG_DEAD;
                    cnt_d = dead;
                end
                LEG_DEAD: begin
                    if (cnt_q == CNT_ZERO) begin // L_EXPIRE
                        st_d = phase ? LEG_ON1 : LEG_ON0;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
                LEG_ON0: begin
                    if (phase) begin             // L_TURN_OFF
                        st_d  = LEG_DEAD;
                        cnt_d = dead;
                    end
                end
                LEG_ON1: begin
                    if (!phase) begin            // L_TURN_OFF
                        st_d  = LEG_DEAD;
                        cnt_d = dead;
                    end
                end
                default: st_d = LEG_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LEG_OFF;
            cnt_q <= CNT_ZERO;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs: decoded from state, gated by inhibit for same-cycle turn-off
    always_comb begin
        out0 = (st_q == LEG_ON0) && !inhibit;
        out1 = (st_q == LEG_ON1) && !inhibit;
    end
endmodule

// File: rtl/psfb_seq.sv
module psfb_seq #(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              term_pulse,
    input  logic [DEAD_W-1:0] dead_a,
    input  logic [DEAD_W-1:0] dead_b,
    input  logic              inhibit,
    output logic              a1,
    output logic              a2,
    output logic              b1,
    output logic              b2
);
    import psfb_pkg::*;

    logic [NUM_LEGS-1:0] leg_phase;
    logic [NUM_LEGS-1:0] leg_out0;
    logic [NUM_LEGS-1:0] leg_out1;
    logic [DEAD_W-1:0]   leg_dead [NUM_LEGS];

    psfb_phase_ctl u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .inhibit    (inhibit),
        .osc_tick   (osc_tick),
        .term_pulse (term_pulse),
        .phase_a    (leg_phase[LEG_A]),
        .phase_b    (leg_phase[LEG_B])
    );

    always_comb begin
        leg_dead[LEG_A] = dead_a;
        leg_dead[LEG_B] = dead_b;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        psfb_leg #(.DEAD_W(DEAD_W)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .inhibit (inhibit),
            .phase   (leg_phase[g]),
            .dead    (leg_dead[g]),
            .out0    (leg_out0[g]),
            .out1    (leg_out1[g])
        );
    end

    always_comb begin
        a2 = leg_out0[LEG_A];
        a1 = leg_out1[LEG_A];
        b1 = leg_out0[LEG_B];
        b2 = leg_out1[LEG_B];
    end
endmodule

// File: rtl/psfb_seq_chk.sv
module psfb_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic inhibit,
    input logic osc_tick,
    input logic term_pulse,
    input logic a1,
    input logic a2,
    input logic b1,
    input logic b2
);
    AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !(a1 || a2 || b1 || b2));                                  // R1
    AST_A_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(a1 && a2));                                                          // R2
    AST_B_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(b1 && b2));                                                          // R2
    AST_A_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && ($fell(a1) || $fell(a2))) |-> $past(osc_tick, 2));        // R4
    AST_B_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && ($fell(b1) || $fell(b2))) |-> $past(term_pulse || osc_tick, 2)); // R5
    AST_A_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(a1) || $rose(a2)) |-> $past(!a1 && !a2));                       // R4
    AST_B_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(b1) || $rose(b2)) |-> $past(!b1 && !b2));                       // R5
endmodule

bind psfb_seq psfb_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inhibit    (inhibit),
    .osc_tick   (osc_tick),
    .term_pulse (term_pulse),
    .a1         (a1),
    .a2         (a2),
    .b1         (b1),
    .b2         (b2)
);

// File: tb/psfb_seq_tb.sv
`timescale 1ns/1ps
module psfb_seq_tb;
    localparam int DW  = 8;
    localparam int DA  = 3;
    localparam int DB  = 5;
    localparam int DB2 = 2;
    localparam int IA1 = 0;
    localparam int IA2 = 1;
    localparam int IB1 = 2;
    localparam int IB2 = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_tick = 1'b0;
    logic          term_pulse = 1'b0;
    logic          inhibit = 1'b0;
    logic [DW-1:0] dead_a = DW'(DA);
    logic [DW-1:0] dead_b = DW'(DB);
    logic          a1, a2, b1, b2;

    int checks   = 0;
    int fails    = 0;
    int overlaps = 0;

    always #2.5 clk = ~clk;

    psfb_seq #(.DEAD_W(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick),
        .term_pulse (term_pulse),
        .dead_a     (dead_a),
        .dead_b     (dead_b),
        .inhibit    (inhibit),
        .a1         (a1),
        .a2         (a2),
        .b1         (b1),
        .b2         (b2)
    );

    always @(negedge clk) if (rst_n && ((a1 && a2) || (b1 && b2))) overlaps++;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outv(int idx);
        case (idx)
            IA1:     return int'(a1);
            IA2:     return int'(a2);
            IB1:     return int'(b1);
            default: return int'(b2);
        endcase
    endfunction

    function automatic int all_out();
        return int'({a1, a2, b1, b2});
    endfunction

    task automatic pulse(bit tk, bit tm);
        @(negedge clk);
        osc_tick   = tk;
        term_pulse = tm;
        @(negedge clk);
        osc_tick   = 1'b0;
        term_pulse = 1'b0;
    endtask

    // called on the sample after a pulse; checks the fall and the low gap
    task automatic watch(string req, int f, int r, int dead);
        int gap;
        chk({req, " high before fall"}, outv(f), 1);
        @(negedge clk);
        chk({req, " falls"}, outv(f), 0);
        gap = 1;
        forever begin
            @(negedge clk);
            if (outv(r) == 1 || gap > 100) break;
            gap++;
        end
        chk({req, " gap"}, gap, dead + 1);
    endtask

    task automatic count_rise(string req, int idx, int dead);
        int n = 0;
        forever begin
            @(negedge clk);
            if (outv(idx) == 1 || n > 100) break;
            n++;
        end
        chk(req, n, dead + 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 outputs low in reset", all_out(), 0);
        rst_n = 1'b1;
        fork
            count_rise("R3 a2 first rise", IA2, DA);
            count_rise("R3 b1 first rise", IB1, DB);
        join
        chk("R3 a1 and b2 stay low", int'(a1) + int'(b2), 0);
    endtask

    task automatic t_term_acts();
        pulse(1'b0, 1'b1);
        watch("R5 b1 to b2", IB1, IB2, DB);
    endtask

    task automatic t_term_ignored();
        pulse(1'b0, 1'b1);
        repeat (DB + 4) @(negedge clk);
        chk("R6 b2 kept", int'(b2), 1);
        chk("R6 b1 kept low", int'(b1), 0);
    endtask

    task automatic t_tick_after_term();
        pulse(1'b1, 1'b0);
        watch("R4 a2 to a1", IA2, IA1, DA);
        chk("R4 B leg untouched by tick", int'(b2), 1);
    endtask

    task automatic t_second_half();
        pulse(1'b0, 1'b1);
        watch("R5 b2 to b1", IB2, IB1, DB);
        pulse(1'b1, 1'b0);
        watch("R4 a1 to a2", IA1, IA2, DA);
    endtask

    task automatic t_forced();
        pulse(1'b1, 1'b0);
        fork
            watch("R7 forced A", IA2, IA1, DA);
            watch("R7 forced B", IB1, IB2, DB);
        join
    endtask

    task automatic t_coincident();
        pulse(1'b1, 1'b1);
        fork
            watch("R7 coincident A", IA1, IA2, DA);
            watch("R7 coincident B", IB2, IB1, DB);
        join
        repeat (4) @(negedge clk);
        chk("R7 single B flip", int'(b1), 1);
    endtask

    task automatic t_dead_reload();
        pulse(1'b0, 1'b1);
        fork
            watch("R8 old setting kept", IB1, IB2, DB);
            begin
                @(negedge clk);
                @(negedge clk);
                dead_b = DW'(DB2);
            end
        join
        pulse(1'b1, 1'b0);
        watch("R4 a2 to a1 again", IA2, IA1, DA);
        pulse(1'b0, 1'b1);
        watch("R8 new setting used", IB2, IB1, DB2);
    endtask

    task automatic t_inhibit();
        @(negedge clk);
        chk("R9 a1 on before inhibit", int'(a1), 1);
        inhibit = 1'b1;
        #1;
        chk("R1 inhibit same cycle", all_out(), 0);
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R9 pulses ignored in inhibit", all_out(), 0);
        inhibit = 1'b0;
        fork
            count_rise("R9 a2 restart", IA2, DA);
            count_rise("R9 b1 restart", IB1, DB2);
        join
        chk("R9 a1 and b2 low after restart", int'(a1) + int'(b2), 0);
    endtask

    initial begin
        t_reset();
        t_term_acts();
        t_term_ignored();
        t_tick_after_term();
        t_second_half();
        t_forced();
        t_coincident();
        t_dead_reload();
        t_inhibit();
        chk("R2 leg overlap count", overlaps, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule